// File: doc/BRIEF.md
# Circular and Bit-Reversed Pointer Update Unit

This block computes the next value of an address pointer for two common DSP addressing schemes. In circular mode, it adds a signed offset to the current pointer and folds the result back into a buffer, so a loop can walk a ring without software bounds checks. In bit-reverse mode, it reorders the low half of the pointer. This ordering is the one that FFT data shuffles use.

A 32-bit modifier word describes the circular buffer. The word carries a buffer length and a small window-size field. When the size field is zero and the length is usable, the buffer starts at an explicit start-address input. Otherwise the block uses a legacy scheme: it derives a power-of-two aligned window from the size field and the current pointer. The result is registered, and a one-bit valid travels with it.

Top module: `circ_addr_gen`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `out_valid` is 0 and `out_ptr` is 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. `out_ptr` loads a new result only on a clock where `in_valid` was 1, and holds its value otherwise.
- R3: The modifier word is decoded as follows. The window field is bits 27:24, read as a signed 4-bit value. The length is bits 16:0, sign-extended to 32 bits. The candidate pointer is `in_ptr + in_offset` modulo 2^32.
- R4: If the window field is 0 and the signed length is at least 4, the buffer uses explicit bounds. It starts at `in_base`, and its end is `in_base + length`.
- R5: In every other case the window is legacy. If the window field W is at least -1, the mask is 2^(W+2)-1; otherwise the mask is 0. The start is `in_ptr` with the masked bits cleared, and the end is start OR length.
- R6: In circular mode, if the candidate is unsigned-greater-than-or-equal to the end, the result is candidate minus length. This test takes priority over the R7 test.
- R7: Otherwise, if the candidate is unsigned-below the start, the result is candidate plus length. Otherwise the result is the candidate unchanged. A single correction is applied, so an offset no larger than the length lands inside the buffer.
- R8: With `in_mode` = 1 (bit-reverse), the result is `in_ptr` with bits 15:0 mirrored (bit i moves to bit 15-i) and bits 31:16 kept. `in_offset`, `in_mod` and `in_base` have no effect. With `in_mode` = 0 the mode is circular.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| in_mode | input | 1 | 0 = circular update, 1 = bit-reverse |
| in_ptr | input | 32 | Current pointer |
| in_offset | input | 32 | Signed increment |
| in_mod | input | 32 | Modifier word: window field and length |
| in_base | input | 32 | Explicit buffer start address |
| out_valid | output | 1 | Result valid |
| out_ptr | output | 32 | Updated pointer |

## Verification
The block keeps no state other than the output register. A wrong bound, mask or correction therefore shows on `out_ptr` on the clock after the operand is accepted. It never shows later. The likely faults are an off-by-one at the end bound, a signed comparison in place of an unsigned one, and a wrong mask width for the legacy field. The tests place candidates exactly on the end bound, one below the start, and within negative and small window fields, so each such fault changes a value that is checked. Because there is no pipeline depth, a stuck or late valid shows up as a mismatch in the very next cycle.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned REV_BITS_DEF = 16;
  localparam int unsigned LEN_W_DEF   = 17;
  localparam int unsigned WIN_LSB_DEF = 24;
  localparam int unsigned WIN_W_DEF   = 4;
  localparam int unsigned MIN_EXPL_LEN = 4;

  typedef enum logic {
    MODE_CIRC = 1'b0,
    MODE_BREV = 1'b1
  } ptr_mode_e;
endpackage

// File: rtl/circ_window.sv
module circ_window #(
  parameter int unsigned ADDR_W  = circ_addr_pkg::ADDR_W_DEF,
  parameter int unsigned LEN_W   = circ_addr_pkg::LEN_W_DEF,
  parameter int unsigned WIN_LSB = circ_addr_pkg::WIN_LSB_DEF,
  parameter int unsigned WIN_W   = circ_addr_pkg::WIN_W_DEF
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] mod_word,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] win_start,
  output logic [ADDR_W-1:0] win_end,
  output logic [ADDR_W-1:0] win_len,
  output logic              explicit_sel
);
  localparam int unsigned SH_W = WIN_W + 1;

  // sign-extend the length field to the address width
  function automatic logic [ADDR_W-1:0] ext_len(input logic [ADDR_W-1:0] m);
    return {{(ADDR_W-LEN_W){m[LEN_W-1]}}, m[LEN_W-1:0]};
  endfunction

  // legacy window mask: 2^(w+2)-1 for w+2 > 0, else zero
  function automatic logic [ADDR_W-1:0] win_mask(input logic signed [WIN_W-1:0] w);
    logic signed [SH_W-1:0] sh;
    sh = SH_W'(w) + $signed(SH_W'(2));
    if (sh > 0) return (ADDR_W'(1) << sh[SH_W-2:0]) - ADDR_W'(1);
    return '0;
  endfunction

  logic signed [WIN_W-1:0] win_fld;
  logic [ADDR_W-1:0]       mask;

  always_comb begin
    win_fld      = mod_word[WIN_LSB +: WIN_W];
    win_len      = ext_len(mod_word);
    mask         = win_mask(win_fld);
    explicit_sel = (win_fld == '0) &&
                   ($signed(win_len) >= $signed(ADDR_W'(circ_addr_pkg::MIN_EXPL_LEN)));
    if (explicit_sel) begin
      win_start = base;
      win_end   = base + win_len;
    end else begin
      win_start = ptr & ~mask;
      win_end   = (ptr & ~mask) | win_len;
    end
  end
endmodule

// File: rtl/circ_wrap.sv
module circ_wrap #(
  parameter int unsigned ADDR_W = circ_addr_pkg::ADDR_W_DEF
) (
  input  logic [ADDR_W-1:0] cand,
  input  logic [ADDR_W-1:0] win_start,
  input  logic [ADDR_W-1:0] win_end,
  input  logic [ADDR_W-1:0] win_len,
  output logic [ADDR_W-1:0] wrapped,
  output logic              wrap_hi,
  output logic              wrap_lo
);
  always_comb begin
    wrap_hi = (cand >= win_end);
    wrap_lo = !wrap_hi && (cand < win_start);
    if (wrap_hi)      wrapped = cand - win_len;
    else if (wrap_lo) wrapped = cand + win_len;
    else              wrapped = cand;
  end
endmodule

// File: rtl/bit_rev.sv
module bit_rev #(
  parameter int unsigned ADDR_W   = circ_addr_pkg::ADDR_W_DEF,
  parameter int unsigned REV_BITS = circ_addr_pkg::REV_BITS_DEF
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  genvar g;
  generate
    for (g = 0; g < REV_BITS; g++) begin : g_mirror
      assign addr_out[g] = addr_in[REV_BITS-1-g];
    end
    if (ADDR_W > REV_BITS) begin : g_keep
      assign addr_out[ADDR_W-1:REV_BITS] = addr_in[ADDR_W-1:REV_BITS];
    end
  endgenerate
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int unsigned ADDR_W   = circ_addr_pkg::ADDR_W_DEF,
  parameter int unsigned REV_BITS = circ_addr_pkg::REV_BITS_DEF,
  parameter int unsigned LEN_W    = circ_addr_pkg::LEN_W_DEF,
  parameter int unsigned WIN_LSB  = circ_addr_pkg::WIN_LSB_DEF,
  parameter int unsigned WIN_W    = circ_addr_pkg::WIN_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [ADDR_W-1:0] in_ptr,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic [ADDR_W-1:0] in_mod,
  input  logic [ADDR_W-1:0] in_base,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_ptr
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic [ADDR_W-1:0] cand, win_start, win_end, win_len;
  logic [ADDR_W-1:0] wrapped, reversed, next_ptr;
  logic              explicit_sel, wrap_hi, wrap_lo;
  logic [ADDR_W-1:0] off_mag;
  logic              off_small, ptr_in_win, win_safe;

  assign cand = in_ptr + in_offset;

  circ_window #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIN_LSB(WIN_LSB), .WIN_W(WIN_W)) u_window (
    .ptr(in_ptr), .mod_word(in_mod), .base(in_base),
    .win_start(win_start), .win_end(win_end), .win_len(win_len),
    .explicit_sel(explicit_sel)
  );

  circ_wrap #(.ADDR_W(ADDR_W)) u_wrap (
    .cand(cand), .win_start(win_start), .win_end(win_end), .win_len(win_len),
    .wrapped(wrapped), .wrap_hi(wrap_hi), .wrap_lo(wrap_lo)
  );

  bit_rev #(.ADDR_W(ADDR_W), .REV_BITS(REV_BITS)) u_brev (
    .addr_in(in_ptr), .addr_out(reversed)
  );

  assign next_ptr = (in_mode == circ_addr_pkg::MODE_BREV) ? reversed : wrapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ptr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_ptr <= next_ptr;
    end
  end

  // named conditions used only by the checks below
  assign off_mag    = in_offset[ADDR_W-1] ? (~in_offset + ADDR_W'(1)) : in_offset;
  assign off_small  = off_mag <= win_len;
  assign ptr_in_win = (in_ptr >= win_start) && (in_ptr < win_end);
  assign win_safe   = (win_start >= win_len) && (win_end > win_start) &&
                      (win_end <= ADDR_MAX - win_len);

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_ptr));
  assert_brev_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode) |=> out_ptr[ADDR_W-1:REV_BITS] == $past(in_ptr[ADDR_W-1:REV_BITS]));
  assert_lands_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode && explicit_sel && ptr_in_win && off_small && win_safe)
      |=> (out_ptr >= $past(win_start)) && (out_ptr < $past(win_end)));
endmodule

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_mode = 1'b0;
  logic [31:0] in_ptr = '0, in_offset = '0, in_mod = '0, in_base = '0;
  logic        out_valid;
  logic [31:0] out_ptr;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  circ_addr_gen i_circ_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_ptr(in_ptr), .in_offset(in_offset), .in_mod(in_mod), .in_base(in_base),
    .out_valid(out_valid), .out_ptr(out_ptr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // independent model of the circular update, written with integers
  function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] o,
                                        input logic [31:0] m, input logic [31:0] b);
    int w, len;
    logic [31:0] s, e, c, mk, ulen;
    w = int'(m[27:24]);
    if (w >= 8) w = w - 16;
    len = int'(m[16:0]);
    if (len >= 65536) len = len - 131072;
    ulen = 32'(len);
    c = p + o;
    if (w == 0 && len >= 4) begin
      s = b; e = b + ulen;
    end else begin
      mk = 0;
      for (int i = 0; i < w + 2; i++) mk[i] = 1'b1;
      s = p & ~mk; e = s | ulen;
    end
    if (c >= e) return c - ulen;
    if (c < s) return c + ulen;
    return c;
  endfunction

  // one operation; result checked one clock later
  task automatic run_op(input string req, input logic mode, input logic [31:0] p,
                        input logic [31:0] o, input logic [31:0] m, input logic [31:0] b,
                        input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_ptr = p; in_offset = o; in_mod = m; in_base = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, out_ptr, exp);
  endtask

  task automatic t_reset;
    check("R1 valid", {31'b0, out_valid}, 32'd0);
    check("R1 ptr", out_ptr, 32'd0);
  endtask

  task automatic t_explicit;
    run_op("R4 inside", 1'b0, 32'h1010, 32'd4, 32'h100, 32'h1000, 32'h1014);
    run_op("R6 past end", 1'b0, 32'h10F0, 32'h20, 32'h100, 32'h1000, 32'h1010);
    run_op("R6 exactly end", 1'b0, 32'h10FC, 32'd4, 32'h100, 32'h1000, 32'h1000);
    run_op("R7 below start", 1'b0, 32'h1008, 32'hFFFF_FFF0, 32'h100, 32'h1000, 32'h10F8);
    run_op("R7 at start", 1'b0, 32'h1004, 32'hFFFF_FFFC, 32'h100, 32'h1000, 32'h1000);
  endtask

  task automatic t_legacy;
    run_op("R5 window 4", 1'b0, 32'h2028, 32'h10, 32'h0400_0030, 32'h9000, 32'h2008);
    run_op("R5 short len", 1'b0, 32'h3001, 32'd1, 32'h0000_0002, 32'h9000, 32'h3000);
    run_op("R5 field -1", 1'b0, 32'h5003, 32'h20, 32'h0F00_0010, 32'h9000, 32'h5013);
    run_op("R5 field -3", 1'b0, 32'h5003, 32'hFFFF_FFFF, 32'h0D00_0010, 32'h9000, 32'h5012);
  endtask

  task automatic t_bitrev;
    run_op("R8 low one", 1'b1, 32'hABCD_0001, 32'h77, 32'h100, 32'h1000, 32'hABCD_8000);
    run_op("R8 pattern", 1'b1, 32'h1357_1234, 32'hFFFF_0000, 32'h0400_0030, 32'h0, 32'h1357_2C48);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    run_op("R2 load", 1'b0, 32'h1010, 32'd8, 32'h100, 32'h1000, 32'h1018);
    prev = out_ptr;
    in_ptr = 32'hDEAD_BEEF; in_offset = 32'h1; in_mode = 1'b1;
    @(negedge clk);
    check("R2 idle valid", {31'b0, out_valid}, 32'd0);
    check("R2 idle hold", out_ptr, prev);
  endtask

  task automatic t_sweep;
    logic [31:0] p, o, m, b;
    for (int i = 0; i < 24; i++) begin
      b = 32'h0001_0000 + 32'(i * 32'h40);
      case (i % 4)
        0: m = 32'h0000_0000 | 32'(8 + i * 3);
        1: m = 32'h0300_0000 | 32'(4 + i);
        2: m = 32'h0000_0002;
        default: m = 32'h0001_FFF8;
      endcase
      p = b + 32'(i * 5 % 16);
      o = (i % 2 == 1) ? 32'(-(i % 7) - 1) : 32'(i % 9);
      run_op("R3 sweep", 1'b0, p, o, m, b, model(p, o, m, b));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_explicit();
    t_legacy();
    t_bitrev();
    t_hold();
    t_sweep();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule